// File: doc/BRIEF.md
# Nine-Bit Address Character Detector

This block sits beside the receive path of a UART that carries 9-bit characters. Each time the deserializer hands a character to the receive FIFO, it presents the 9-bit word with a one-cycle strobe. The block does two independent things with it. First, it raises a top-priority address interrupt when a character with its ninth bit set arrives. That interrupt stays up until the flagged character has been read out of the FIFO. Second, it compares the word against four programmable 9-bit patterns and raises a match interrupt carrying the index of the pattern that hit.

A small mode register controls both paths. Bit 0 turns on 9-bit operation. Bit 1 turns on the address interrupt. Bits 2 to 5 supply the ninth bit of patterns 0 to 3, whose low eight bits come from four external special-character registers. Bits 7 and 6 are not stored. Pattern matching also needs the enhanced-mode input and the match interrupt enable input. A status read clears a pending match.

The block follows FIFO occupancy from the push strobe and the pop strobe. This lets it release the address interrupt exactly when the last flagged character leaves. The FIFO storage itself is not part of this block.

Top module: `addr9_detect`

## Requirements
- R1: After reset, `mode_rdata` reads 0x00, and `addr_irq` and `match_irq` are both 0.
- R2: A write on `mode_wr` stores `mode_wdata[5:0]`, and the register reads back on the following cycle. Bits 7 and 6 of `mode_rdata` always read 0, whatever was written.
- R3: While mode bit 0 is 0, received characters raise neither `addr_irq` nor `match_irq`.
- R4: With mode bits 0 and 1 both set, a character with `rx_char[8]`=1 drives `addr_irq` high in the cycle after its strobe. With mode bit 1 clear, `addr_irq` stays 0.
- R5: `addr_irq` stays high until the most recently flagged character is popped. Occupancy counts one per accepted `rx_valid` and minus one per `fifo_pop` when the FIFO is not empty. If more address characters are queued, the interrupt stays up until the last of them leaves.
- R6: Pattern i (0..3) is {mode bit 2+i, `spc_chars[8i+7:8i]`}. A received character equal to a pattern sets `match_irq` in the cycle after its strobe, with `match_idx`=i.
- R7: Matching happens only when mode bit 0, `enh_mode` and `match_ie` are all 1.
- R8: When several patterns equal the same character, `match_idx` reports the lowest index.
- R9: `match_irq` holds until a cycle with `stat_rd`=1, which clears it. A new match in the same cycle as `stat_rd` wins, and its index is loaded. A later non-matching character leaves both the flag and the index unchanged.
- R10: The ninth bit takes part in the comparison. A character that equals a pattern's low eight bits but differs in bit 8 does not match.
- R11: With FIFO_DEPTH characters held and no pop in the same cycle, a further strobe is dropped. It is not counted and never raises `addr_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Character transferred into the receive FIFO this cycle |
| rx_char | input | 9 | Received 9-bit character |
| fifo_pop | input | 1 | One character read out of the receive FIFO |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register read value |
| spc_chars | input | 32 | Low eight bits of patterns 0..3, pattern i in bits 8i+7:8i |
| enh_mode | input | 1 | Enhanced mode enable |
| match_ie | input | 1 | Pattern-match interrupt enable |
| stat_rd | input | 1 | Status read, clears a pending match |
| addr_irq | output | 1 | Address character interrupt (highest priority) |
| match_irq | output | 1 | Pattern match interrupt |
| match_idx | output | 2 | Index of the pattern that matched |

## Verification
The occupancy and flagged-position counters can be wrong internally, and that shows at the ports as a mistimed `addr_irq` release. If the position is off by one, the interrupt drops one pop early or one pop late. That becomes visible within a single pop of the flagged character, which the queue sequences and the full-FIFO case expose. A wrong comparator or priority shows as a wrong `match_irq` or `match_idx` one cycle after the strobe. Every 9-bit value is swept against two pattern sets, one of them with duplicate patterns, so any single bad compare bit shows up in the first character that depends on it. The mode register shows its state directly on `mode_rdata` one cycle after each write.

// File: rtl/addr9_pkg.sv
package addr9_pkg;
  localparam int CHAR_W  = 8;
  localparam int WORD_W  = CHAR_W + 1;
  localparam int NUM_PAT = 4;
  localparam int MODE_W  = 8;
  localparam int IDX_W   = $clog2(NUM_PAT);

  typedef struct packed {
    logic [NUM_PAT-1:0] pat9;     // ninth bits of patterns (bit 2+i)
    logic               addr_ie;  // bit 1
    logic               nine_en;  // bit 0
  } mode_t;

  localparam int STORED_W = $bits(mode_t);
endpackage

// File: rtl/a9_mode_reg.sv
module a9_mode_reg
  import addr9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  output mode_t             mode_q,
  output logic [MODE_W-1:0] rdata
);
  mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr) mode_d = mode_t'(wdata[STORED_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign rdata = {{(MODE_W-STORED_W){1'b0}}, mode_q};

  // R2
  mode_wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (rdata[STORED_W-1:0] == $past(wdata[STORED_W-1:0])));
endmodule

// File: rtl/a9_pat_match.sv
module a9_pat_match #(
  parameter int NUM_PAT = 4,
  parameter int CHAR_W  = 8,
  localparam int WORD_W = CHAR_W + 1,
  localparam int IDX_W  = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid,
  input  logic [WORD_W-1:0]         rx_word,
  input  logic [NUM_PAT*CHAR_W-1:0] spc_flat,
  input  logic [NUM_PAT-1:0]        pat9,
  input  logic                      active,
  input  logic                      stat_rd,
  output logic                      match_irq,
  output logic [IDX_W-1:0]          match_idx
);
  logic [NUM_PAT-1:0] hits;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_sel;
  logic               irq_d;
  logic [IDX_W-1:0]   idx_d;
  logic               load_en;

  for (genvar gi = 0; gi < NUM_PAT; gi++) begin : g_cmp
    logic [WORD_W-1:0] pattern;
    assign pattern  = {pat9[gi], spc_flat[gi*CHAR_W +: CHAR_W]};
    assign hits[gi] = (rx_word == pattern);
  end

  always_comb begin
    hit_sel = '0;
    for (int i = NUM_PAT - 1; i >= 0; i--) begin
      if (hits[i]) hit_sel = IDX_W'(i);
    end
  end

  assign hit_any = |hits;
  assign load_en = rx_valid && active && hit_any;

  always_comb begin
    irq_d = match_irq;
    idx_d = match_idx;
    if (stat_rd) irq_d = 1'b0;
    if (load_en) begin
      irq_d = 1'b1;
      idx_d = hit_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_irq <= 1'b0;
      match_idx <= '0;
    end else begin
      match_irq <= irq_d;
      match_idx <= idx_d;
    end
  end

  // R7
  match_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_irq) |-> $past(rx_valid && active));
  // R9
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_valid) |=> !match_irq);
  // R8
  lowest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && active && hits[0]) |=> (match_idx == '0));
endmodule

// File: rtl/a9_addr_track.sv
module a9_addr_track #(
  parameter int DEPTH = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic rx_ninth,
  input  logic flag_en,
  input  logic fifo_pop,
  output logic addr_pend
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic [OCC_W-1:0] pos_q, pos_d, pos_dec;
  logic             pop_ok, push_ok, flag;

  always_comb begin
    pop_ok  = fifo_pop && (occ_q != '0);
    push_ok = rx_valid && ((occ_q != FULL) || pop_ok);
    flag    = push_ok && flag_en && rx_ninth;
    occ_d   = occ_q;
    if (push_ok && !pop_ok)      occ_d = occ_q + 1'b1;
    else if (pop_ok && !push_ok) occ_d = occ_q - 1'b1;
    pos_dec = (pop_ok && (pos_q != '0)) ? pos_q - 1'b1 : pos_q;
    pos_d   = flag ? occ_d : pos_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      pos_q <= '0;
    end else begin
      occ_q <= occ_d;
      pos_q <= pos_d;
    end
  end

  assign addr_pend = (pos_q != '0);

  // R11
  occ_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL);
  // R5
  pos_within_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= occ_q);
  // R5
  pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_pend) |-> $past(fifo_pop));
endmodule

// File: rtl/addr9_detect.sv
module addr9_detect
  import addr9_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid,
  input  logic [WORD_W-1:0]         rx_char,
  input  logic                      fifo_pop,
  input  logic                      mode_wr,
  input  logic [MODE_W-1:0]         mode_wdata,
  output logic [MODE_W-1:0]         mode_rdata,
  input  logic [NUM_PAT*CHAR_W-1:0] spc_chars,
  input  logic                      enh_mode,
  input  logic                      match_ie,
  input  logic                      stat_rd,
  output logic                      addr_irq,
  output logic                      match_irq,
  output logic [IDX_W-1:0]          match_idx
);
  mode_t mode;
  logic  addr_pend;
  logic  match_active;
  logic  flag_en;

  a9_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mode_wr),
    .wdata  (mode_wdata),
    .mode_q (mode),
    .rdata  (mode_rdata)
  );

  assign flag_en      = mode.nine_en && mode.addr_ie;
  assign match_active = mode.nine_en && enh_mode && match_ie;

  a9_addr_track #(.DEPTH(FIFO_DEPTH)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ninth  (rx_char[WORD_W-1]),
    .flag_en   (flag_en),
    .fifo_pop  (fifo_pop),
    .addr_pend (addr_pend)
  );

  assign addr_irq = addr_pend && flag_en;

  a9_pat_match #(.NUM_PAT(NUM_PAT), .CHAR_W(CHAR_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_word   (rx_char),
    .spc_flat  (spc_chars),
    .pat9      (mode.pat9),
    .active    (match_active),
    .stat_rd   (stat_rd),
    .match_irq (match_irq),
    .match_idx (match_idx)
  );

  // R4
  addr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_irq) |-> ($past(rx_valid && rx_char[WORD_W-1]) || $past(mode_wr)));
  // R3
  nine_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.nine_en && !mode_wr && !match_irq) |=> !match_irq);
endmodule

// File: tb/sim_addr9_detect.sv
module sim_addr9_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, fifo_pop, mode_wr, enh_mode, match_ie, stat_rd;
  logic [8:0]  rx_char;
  logic [7:0]  mode_wdata, mode_rdata;
  logic [31:0] spc_chars;
  logic        addr_irq, match_irq;
  logic [1:0]  match_idx;
  int checks = 0;
  int failures = 0;
  logic [7:0]  cur_mode;

  always #5 clk = ~clk;

  addr9_detect u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .fifo_pop(fifo_pop), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata), .spc_chars(spc_chars), .enh_mode(enh_mode),
    .match_ie(match_ie), .stat_rd(stat_rd), .addr_irq(addr_irq),
    .match_irq(match_irq), .match_idx(match_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [8:0] d, input logic pop, input logic rd);
    @(negedge clk);
    rx_valid = v; rx_char = d; fifo_pop = pop; stat_rd = rd;
    @(negedge clk);
    rx_valid = 1'b0; fifo_pop = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic wmode(input logic [7:0] m);
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = m; cur_mode = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  // expected index, or -1 when no pattern equals d
  function automatic int exp_idx(input logic [8:0] d, input logic [7:0] m, input logic [31:0] s);
    int r = -1;
    for (int i = 3; i >= 0; i--)
      if (d == {m[2+i], s[i*8 +: 8]}) r = i;
    return r;
  endfunction

  task automatic sweep(input string tag);
    for (int v = 0; v < 512; v++) begin
      logic [8:0] d = 9'(v);
      int e = exp_idx(d, cur_mode, spc_chars);
      cyc(1'b1, d, 1'b0, 1'b0);
      chk({tag, " R6 R10 match"}, int'(match_irq), (e >= 0) ? 1 : 0);
      if (e >= 0) chk({tag, " R8 idx"}, int'(match_idx), e);
      chk({tag, " R4 addr"}, int'(addr_irq), int'(d[8] & cur_mode[1] & cur_mode[0]));
      cyc(1'b0, 9'h0, 1'b1, 1'b1);
      chk({tag, " R9 cleared"}, int'(match_irq), 0);
      chk({tag, " R5 popped"}, int'(addr_irq), 0);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 0; rx_char = '0; fifo_pop = 0; mode_wr = 0;
    mode_wdata = '0; enh_mode = 1; match_ie = 1; stat_rd = 0; cur_mode = '0;
    spc_chars = {8'hC3, 8'h7E, 8'h41, 8'h41};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 mode", int'(mode_rdata), 0);
    chk("R1 addr", int'(addr_irq), 0);
    chk("R1 match", int'(match_irq), 0);
    // R2
    wmode(8'hFF); chk("R2 ff", int'(mode_rdata), 8'h3F);
    wmode(8'hA5); chk("R2 a5", int'(mode_rdata), 8'h25);

    // Config A: patterns 0x041,0x141,0x07E,0x1C3; address interrupt on
    wmode({2'b00, 4'b1010, 2'b11});
    sweep("cfgA");
    // Config B: all low bytes 0x55, ninth 1,1,0,1; address interrupt off
    spc_chars = {4{8'h55}};
    wmode({2'b00, 4'b1011, 2'b01});
    sweep("cfgB");

    // R7 / R3: enable combinations
    spc_chars = {8'hC3, 8'h7E, 8'h41, 8'h41};
    for (int c = 0; c < 8; c++) begin
      wmode({2'b00, 4'b1010, 1'b1, c[0]});
      enh_mode = c[1]; match_ie = c[2];
      cyc(1'b1, 9'h141, 1'b0, 1'b0);
      chk("R7 R3 match gate", int'(match_irq), (c == 7) ? 1 : 0);
      chk("R3 addr gate", int'(addr_irq), c[0]);
      cyc(1'b0, 9'h0, 1'b1, 1'b1);
    end
    enh_mode = 1; match_ie = 1;
    wmode({2'b00, 4'b1010, 2'b11});

    // R9 hold, non-match leaves state, simultaneous set wins
    cyc(1'b1, 9'h07E, 1'b0, 1'b0);
    cyc(1'b0, 9'h0, 1'b0, 1'b0);
    chk("R9 hold", int'(match_irq), 1);
    cyc(1'b1, 9'h17E, 1'b0, 1'b0);
    chk("R9 R10 nonmatch keeps", int'(match_irq), 1);
    chk("R9 idx kept", int'(match_idx), 2);
    cyc(1'b1, 9'h1C3, 1'b0, 1'b1);
    chk("R9 set wins", int'(match_irq), 1);
    chk("R9 new idx", int'(match_idx), 3);
    cyc(1'b0, 9'h0, 1'b1, 1'b1);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);
    chk("R9 clear", int'(match_irq), 0);
    chk("R5 empty", int'(addr_irq), 0);

    // R5: normal, address, normal
    cyc(1'b1, 9'h012, 1'b0, 1'b0);
    cyc(1'b1, 9'h112, 1'b0, 1'b0);
    cyc(1'b1, 9'h013, 1'b0, 1'b0);
    chk("R5 queued", int'(addr_irq), 1);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);
    chk("R5 ahead popped", int'(addr_irq), 1);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);
    chk("R5 flagged popped", int'(addr_irq), 0);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);
    // R5: two address characters
    cyc(1'b1, 9'h1A0, 1'b0, 1'b0);
    cyc(1'b1, 9'h1A1, 1'b0, 1'b0);
    cyc(1'b1, 9'h0A2, 1'b0, 1'b0);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);
    chk("R5 second still queued", int'(addr_irq), 1);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);
    chk("R5 last address gone", int'(addr_irq), 0);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);

    // R11: full FIFO drops the strobe
    for (int k = 0; k < 16; k++) cyc(1'b1, 9'h000, 1'b0, 1'b0);
    cyc(1'b1, 9'h100, 1'b0, 1'b0);
    chk("R11 dropped", int'(addr_irq), 0);
    cyc(1'b1, 9'h100, 1'b1, 1'b0);
    chk("R11 accepted with pop", int'(addr_irq), 1);
    for (int k = 0; k < 15; k++) cyc(1'b0, 9'h0, 1'b1, 1'b0);
    chk("R11 R5 before last", int'(addr_irq), 1);
    cyc(1'b0, 9'h0, 1'b1, 1'b0);
    chk("R11 R5 drained", int'(addr_irq), 0);
    cyc(1'b1, 9'h100, 1'b0, 1'b0);
    chk("R11 count intact", int'(addr_irq), 1);
    cyc(1'b0, 9'h0, 1'b1, 1'b1);
    chk("R11 count zero", int'(addr_irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule